// File: doc/BRIEF.md
# Calendar Alarm Match and Interrupt Generator

This block watches a BCD calendar time supplied by an external timekeeping counter. It compares that time with six programmable alarm fields: seconds, minutes, hours, date, month and weekday. Each field has its own enable flag, so software can match on any subset of the fields. For example, it can match only on the seconds value, or on the full date and time. The comparison is made only on cycles where the counter pulses `tick_i` to show that a new time value has just been presented.

When a match occurs, the block sets an alarm flag that software can read. It also pulls the active-low interrupt output low, in one of two ways. In single-event mode the interrupt stays low until software clears the flag. In pulsed mode the interrupt stays low for a fixed number of clock cycles after every match, and nothing has to be cleared for the next pulse to occur.

Software reaches the alarm bytes, a control byte and a status byte through a plain write-enable/address/data port. Reads on that port are combinational.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset every register address (0..15) reads 00h and `irq_no` is high.
- R2: Addresses 0..5 hold the seconds, minutes, hours, date, month and weekday alarm bytes and read back exactly as written. Address 6 is the control byte: only bit 7 (mode, 1 = pulsed) and bit 6 (alarm enable) are stored, and the other bits read 0. Address 7 is status, with the alarm flag in bit 0. Addresses 8..15 read 00h.
- R3: A trigger happens on a `tick_i` cycle only when every alarm byte whose bit 7 is 1 has bits 6:0 equal to bits 6:0 of its time input.
- R4: The bits 6:0 of an alarm byte whose bit 7 is 0 have no effect on matching.
- R5: When control bit 6 is 0, or when no alarm byte has bit 7 set, no trigger occurs and `irq_no` stays high.
- R6: A trigger sets status bit 0 and drives `irq_no` low. Both are visible after the clock edge that samples `tick_i`.
- R7: In single-event mode `irq_no` stays low until software writes status with bit 0 = 0. A status write with bit 0 = 1 changes nothing, and further triggers cause no change.
- R8: In pulsed mode each trigger holds `irq_no` low for exactly PULSE_CYCLES cycles and then releases it, and this repeats on every trigger without the flag being cleared. With only seconds = 30 enabled, one pulse occurs per minute of time input.
- R9: A time input that matches but arrives without `tick_i` does not trigger.
- R10: When a trigger and a clearing status write happen in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe: the time inputs carry a new value |
| sec_i | input | 8 | Current seconds, BCD |
| min_i | input | 8 | Current minutes, BCD |
| hour_i | input | 8 | Current hours, BCD |
| date_i | input | 8 | Current day of month, BCD |
| month_i | input | 8 | Current month, BCD |
| wday_i | input | 8 | Current weekday, BCD |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Combinational read data for `addr_i` |
| irq_no | output | 1 | Alarm interrupt, active low |

## Verification
Every result of the block appears one clock edge after the cycle that causes it. The flag and `irq_no` change at the edge that samples a matching tick. A pulse then lasts PULSE_CYCLES further edges, and a clearing write takes effect at its own write edge. The bench drives on falling edges and samples on the next falling edge, so the first check after a tick sees the new state and each later sample advances exactly one edge. A sweep over all 64 field-enable masks checks the match rule against a time that differs in each single field in turn. A sweep of three minutes of seconds in pulsed mode checks the pulse width and how often pulses repeat.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int NUM_FIELDS = 6;
  localparam int DW         = 8;
  localparam int AW         = 4;
  localparam logic [AW-1:0] ADDR_CTRL = AW'(6);
  localparam logic [AW-1:0] ADDR_STAT = AW'(7);

  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_PULSE  = 1'b1
  } irq_mode_e;

  typedef struct packed {
    irq_mode_e mode;
    logic      en;
  } ctrl_t;
endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
  import rtc_alarm_pkg::*;
#(
  parameter int NF = NUM_FIELDS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [DW-1:0]         wdata_i,
  input  logic                  alm_i,
  output logic [NF-1:0][DW-1:0] field_o,
  output ctrl_t                 ctrl_o,
  output logic                  clr_o,
  output logic [DW-1:0]         rdata_o
);
  logic [NF-1:0][DW-1:0] field_q;
  ctrl_t                 ctrl_q;

  for (genvar i = 0; i < NF; i++) begin : g_field
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               field_q[i] <= '0;
      else if (wr_en_i && addr_i == AW'(i))      field_q[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               ctrl_q <= '{mode: MODE_SINGLE, en: 1'b0};
    else if (wr_en_i && addr_i == ADDR_CTRL)   ctrl_q <= '{mode: irq_mode_e'(wdata_i[DW-1]), en: wdata_i[DW-2]};
  end

  // status write with bit 0 low requests a flag clear
  assign clr_o   = wr_en_i && (addr_i == ADDR_STAT) && !wdata_i[0];
  assign field_o = field_q;
  assign ctrl_o  = ctrl_q;

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NF; i++) begin
      if (addr_i == AW'(i)) rdata_o = field_q[i];
    end
    if (addr_i == ADDR_CTRL) rdata_o = {ctrl_q.mode, ctrl_q.en, {(DW-2){1'b0}}};
    if (addr_i == ADDR_STAT) rdata_o = {{(DW-1){1'b0}}, alm_i};
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_alarm_pkg::*;
#(
  parameter int NF = NUM_FIELDS
) (
  input  logic [NF-1:0][DW-1:0] field_i,
  input  logic [NF-1:0][DW-1:0] time_i,
  output logic                  hit_o
);
  logic [NF-1:0] used;
  logic [NF-1:0] ok;

  for (genvar i = 0; i < NF; i++) begin : g_cmp
    assign used[i] = field_i[i][DW-1];
    assign ok[i]   = !used[i] || (field_i[i][DW-2:0] == time_i[i][DW-2:0]);
  end

  assign hit_o = (&ok) && (|used);
endmodule

// File: rtl/rtc_alarm_irq_gen.sv
module rtc_alarm_irq_gen
  import rtc_alarm_pkg::*;
#(
  parameter int PULSE_CYCLES = 4,
  parameter int CNT_W        = $clog2(PULSE_CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             hit_i,
  input  ctrl_t            ctrl_i,
  input  logic             clr_i,
  output logic             alm_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_no
);
  logic             trig;
  logic             alm_q;
  logic [CNT_W-1:0] cnt_q;

  assign trig = tick_i && hit_i && ctrl_i.en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     alm_q <= 1'b0;
    else if (trig)   alm_q <= 1'b1;   // set beats clear
    else if (clr_i)  alm_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               cnt_q <= '0;
    else if (trig && ctrl_i.mode == MODE_PULSE) cnt_q <= CNT_W'(PULSE_CYCLES);
    else if (cnt_q != '0)                      cnt_q <= cnt_q - 1'b1;
  end

  assign alm_o  = alm_q;
  assign cnt_o  = cnt_q;
  assign irq_no = (ctrl_i.mode == MODE_PULSE) ? (cnt_q == '0) : !alm_q;
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_alarm_pkg::*;
#(
  parameter int PULSE_CYCLES = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [DW-1:0] sec_i,
  input  logic [DW-1:0] min_i,
  input  logic [DW-1:0] hour_i,
  input  logic [DW-1:0] date_i,
  input  logic [DW-1:0] month_i,
  input  logic [DW-1:0] wday_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_no
);
  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);

  logic [NUM_FIELDS-1:0][DW-1:0] field;
  logic [NUM_FIELDS-1:0][DW-1:0] now;
  ctrl_t                         ctrl;
  logic                          clr;
  logic                          alm;
  logic                          hit;
  logic [CNT_W-1:0]              cnt;

  // field order follows register addresses 0..5
  assign now = {wday_i, month_i, date_i, hour_i, min_i, sec_i};

  rtc_alarm_regs #(.NF(NUM_FIELDS)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .alm_i(alm), .field_o(field), .ctrl_o(ctrl), .clr_o(clr), .rdata_o
  );

  rtc_alarm_cmp #(.NF(NUM_FIELDS)) u_cmp (
    .field_i(field), .time_i(now), .hit_o(hit)
  );

  rtc_alarm_irq_gen #(.PULSE_CYCLES(PULSE_CYCLES), .CNT_W(CNT_W)) u_gen (
    .clk_i, .rst_ni, .tick_i, .hit_i(hit), .ctrl_i(ctrl), .clr_i(clr),
    .alm_o(alm), .cnt_o(cnt), .irq_no
  );
endmodule

// File: rtl/rtc_alarm_irq_chk.sv
module rtc_alarm_irq_chk #(
  parameter int PULSE_CYCLES = 4,
  parameter int CNT_W        = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             hit,
  input logic             en,
  input logic             mode,
  input logic             clr,
  input logic             alm,
  input logic [CNT_W-1:0] cnt
);
  logic trig;
  assign trig = tick_i && hit && en;

  a_r9_flag_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alm) |-> $past(tick_i));

  a_r5_flag_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alm) |-> $past(en && hit));

  a_r7_flag_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alm && !clr) |=> alm);

  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig && clr) |=> alm);

  a_r8_pulse_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig && mode) |=> (cnt == CNT_W'(PULSE_CYCLES)));

  a_r8_pulse_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt != '0 && !(trig && mode)) |=> (cnt == $past(cnt) - 1'b1));
endmodule

bind rtc_alarm_irq rtc_alarm_irq_chk #(.PULSE_CYCLES(PULSE_CYCLES), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .hit(hit), .en(ctrl.en),
  .mode(ctrl.mode), .clr(clr), .alm(alm), .cnt(cnt)
);

// File: tb/rtc_alarm_irq_bench.sv
`timescale 1ns/1ps
module rtc_alarm_irq_bench;
  localparam int PC = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_n;
  logic [7:0] tm [6];

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rtc_alarm_irq #(.PULSE_CYCLES(PC)) u_rtc_alarm_irq (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .sec_i(tm[0]), .min_i(tm[1]), .hour_i(tm[2]),
    .date_i(tm[3]), .month_i(tm[4]), .wday_i(tm[5]),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_no(irq_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input int exp);
    addr = a; #1;
    chk(req, int'(rdata), exp);
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  function automatic logic [7:0] bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] base [6];
    base = '{8'h45, 8'h30, 8'h11, 8'h01, 8'h01, 8'h03};
    for (int i = 0; i < 6; i++) tm[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 16; a++) rd_chk("R1", 4'(a), 0);
    chk("R1 irq", int'(irq_n), 1);

    // R2 readback
    for (int a = 0; a < 6; a++) begin
      wr(4'(a), 8'(8'h5A + a * 17));
      rd_chk("R2 field", 4'(a), int'(8'(8'h5A + a * 17)));
    end
    wr(4'd6, 8'hFF); rd_chk("R2 ctrl", 4'd6, 8'hC0);
    wr(4'd9, 8'hFF); rd_chk("R2 unmapped", 4'd9, 0);
    wr(4'd6, 8'h00);

    // R3 R4 R5: sweep all enable masks, single-event mode
    wr(4'd6, 8'h40);
    for (int m = 0; m < 64; m++) begin
      for (int f = 0; f < 6; f++) wr(4'(f), (m[f] ? 8'h80 : 8'h00) | base[f]);
      for (int v = 0; v < 7; v++) begin
        bit exp;
        for (int f = 0; f < 6; f++) tm[f] = (f == v) ? (base[f] ^ 8'h01) : base[f];
        do_tick();
        exp = (m != 0) && (v == 6 || !m[v]);
        chk(m == 0 ? "R5 no field" : (v == 6 ? "R3 exact" : "R4 field"), int'(irq_n), int'(!exp));
        rd_chk("R6 flag", 4'd7, int'(exp));
        wr(4'd7, 8'h00);
      end
    end

    // R5: enable off with a matching time
    for (int f = 0; f < 6; f++) begin wr(4'(f), 8'h80 | base[f]); tm[f] = base[f]; end
    wr(4'd6, 8'h00);
    do_tick();
    chk("R5 enable off", int'(irq_n), 1);
    rd_chk("R5 enable off flag", 4'd7, 0);

    // R9: matching time without strobe
    wr(4'd6, 8'h40);
    repeat (3) @(negedge clk);
    chk("R9 no tick", int'(irq_n), 1);
    rd_chk("R9 no tick flag", 4'd7, 0);

    // R6 R7 single-event hold and clear
    do_tick();
    chk("R6 irq low", int'(irq_n), 0);
    repeat (5) @(negedge clk);
    chk("R7 held", int'(irq_n), 0);
    do_tick();
    chk("R7 retrigger", int'(irq_n), 0);
    wr(4'd7, 8'h01);
    chk("R7 write one", int'(irq_n), 0);
    rd_chk("R7 flag kept", 4'd7, 1);
    wr(4'd7, 8'h00);
    chk("R7 cleared", int'(irq_n), 1);
    rd_chk("R7 flag cleared", 4'd7, 0);

    // R10 set wins over clear
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; addr = 4'd7; wdata = 8'h00;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    rd_chk("R10 set wins", 4'd7, 1);
    wr(4'd7, 8'h00);

    // R8 pulsed mode, seconds = 30 only, three minutes
    wr(4'd0, 8'hB0);
    for (int f = 1; f < 6; f++) wr(4'(f), 8'h00);
    wr(4'd6, 8'hC0);
    begin
      int pulses = 0;
      for (int mn = 0; mn < 3; mn++) begin
        for (int s = 0; s < 60; s++) begin
          tm[0] = bcd(s); tm[1] = bcd(mn);
          do_tick();
          if (irq_n == 1'b0) pulses++;
          for (int k = 0; k < PC + 2; k++) begin
            if (k > 0) @(negedge clk);
            chk("R8 pulse", int'(irq_n), int'(!(s == 30 && k < PC)));
          end
        end
      end
      chk("R8 pulse count", pulses, 3);
      rd_chk("R8 flag set", 4'd7, 1);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule